// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a four-bit counter driven by two count strobes, one that steps the value up and one that steps it down. A parameter chooses decade operation (values 0 to 9) or binary operation (values 0 to 15). A high clear input forces the value to zero at once. A low load input copies a four-bit preset word into the value at once, without waiting for a clock. Both strobes are sampled by a single system clock through a two-flop synchroniser, and a count happens on a synchronised rising edge.

Two active-low terminal outputs support cascading. The carry output goes low while the value sits at its mode maximum and the up strobe is low. The borrow output goes low while the value is zero and the down strobe is low. Each output rises again at the same time as the strobe edge that wraps the value. A wider counter is built by feeding carry into the up strobe of the next stage and borrow into its down strobe, with clear and load shared between stages.

Top module: `updn_counter`

## Requirements
- R1: A rising edge on `up_clk_i` while `dn_clk_i` is high adds one to `count_o` on the third rising `clk` edge after the strobe rises. A rising edge on `up_clk_i` while `dn_clk_i` is low leaves the value unchanged.
- R2: A rising edge on `dn_clk_i` while `up_clk_i` is high subtracts one from `count_o`. The timing is the same as in R1.
- R3: If rising edges of both strobes reach the synchronised domain in the same `clk` cycle, the value holds.
- R4: While `clear_i` is 1, `count_o` is 0. This holds without a clock edge and overrides the load input, the preset word and both strobes.
- R5: While `load_n_i` is 0 and `clear_i` is 0, `count_o` equals `preset_i`. This holds without a clock edge, and strobe edges during that time have no effect. After `load_n_i` returns high, the value stays at the preset.
- R6: `carry_n_o` is 0 only while `count_o` equals the mode maximum (9 in decade mode, 15 in binary mode) and the synchronised up strobe is low. Otherwise it is 1.
- R7: `borrow_n_o` is 0 only while `count_o` is 0 and the synchronised down strobe is low. Otherwise it is 1.
- R8: Counting up from the maximum wraps to 0, and counting down from 0 wraps to the maximum. In decade mode, a value in 0 to 9 never leaves that range by counting.
- R9: In decade mode, out-of-range values return to 0–9 within two counts.
  - Counting up: 10, 12 and 14 go to 11, 13 and 15, and 11, 13 and 15 go to 0.
  - Counting down: 10 goes to 9, 11, 13 and 15 go to 10, 12 and 14, and 12 and 14 go to 9.
- R10: While `rst_n` is low the value is 0. Both synchronised strobes read high, so no edge is seen when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low system reset |
| up_clk_i | input | 1 | Count-up strobe; a rising edge counts up |
| dn_clk_i | input | 1 | Count-down strobe; a rising edge counts down |
| load_n_i | input | 1 | Active-low asynchronous preset load |
| clear_i | input | 1 | Active-high asynchronous clear |
| preset_i | input | 4 | Preset word copied in by the load |
| count_o | output | 4 | Current count value |
| carry_n_o | output | 1 | Active-low terminal count for counting up |
| borrow_n_o | output | 1 | Active-low terminal count for counting down |

## Verification
The step properties assume each strobe level lasts long enough to pass the two-flop synchroniser. They also assume a count is judged only across cycles in which clear and load are both inactive. The stimulus holds every strobe level for four system cycles and raises the strobes one at a time, except in the simultaneous-edge case. Load and clear change only at falling `clk` edges, so the asynchronous override is observed between rising edges.

// File: rtl/updn_ctr_pkg.sv
`timescale 1ns/1ps
package updn_ctr_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/ctr_edge_sync.sv
`timescale 1ns/1ps
module ctr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
    logic [STAGES:0] chain_d;
    logic [STAGES:0] chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/ctr_step_decode.sv
`timescale 1ns/1ps
module ctr_step_decode
    import updn_ctr_pkg::*;
(
    input  logic  up_lvl_i,
    input  logic  up_rise_i,
    input  logic  dn_lvl_i,
    input  logic  dn_rise_i,
    output step_e step_o
);
    always_comb begin
        step_o = STEP_HOLD;
        if (up_rise_i && !dn_rise_i && dn_lvl_i) begin
            step_o = STEP_UP;
        end else if (dn_rise_i && !up_rise_i && up_lvl_i) begin
            step_o = STEP_DOWN;
        end
    end
endmodule

// File: rtl/ctr_next_value.sv
`timescale 1ns/1ps
module ctr_next_value
    import updn_ctr_pkg::*;
#(
    parameter int W      = 4,
    parameter bit DECADE = 1'b1,
    parameter int MAX    = 9
) (
    input  logic [W-1:0] cur_i,
    input  step_e        step_i,
    output logic [W-1:0] nxt_o
);
    localparam logic [W-1:0] TOP   = W'(MAX);
    localparam logic [W-1:0] FIRST = W'(MAX + 1);

    generate
        if (DECADE) begin : g_decade
            always_comb begin
                nxt_o = cur_i;
                unique case (step_i)
                    STEP_UP: begin
                        if (cur_i == TOP) begin
                            nxt_o = '0;
                        end else if (cur_i > TOP) begin
                            nxt_o = cur_i[0] ? '0 : cur_i + 1'b1;
                        end else begin
                            nxt_o = cur_i + 1'b1;
                        end
                    end
                    STEP_DOWN: begin
                        if (cur_i == '0) begin
                            nxt_o = TOP;
                        end else if (cur_i == FIRST) begin
                            nxt_o = TOP;
                        end else if (cur_i > TOP) begin
                            nxt_o = cur_i[0] ? cur_i - 1'b1 : TOP;
                        end else begin
                            nxt_o = cur_i - 1'b1;
                        end
                    end
                    default: nxt_o = cur_i;
                endcase
            end
        end else begin : g_binary
            always_comb begin
                nxt_o = cur_i;
                unique case (step_i)
                    STEP_UP:   nxt_o = (cur_i == TOP) ? '0 : cur_i + 1'b1;
                    STEP_DOWN: nxt_o = (cur_i == '0) ? TOP : cur_i - 1'b1;
                    default:   nxt_o = cur_i;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/ctr_terminal.sv
`timescale 1ns/1ps
module ctr_terminal #(
    parameter int W   = 4,
    parameter int MAX = 9
) (
    input  logic [W-1:0] count_i,
    input  logic         up_lvl_i,
    input  logic         dn_lvl_i,
    output logic         carry_n_o,
    output logic         borrow_n_o
);
    localparam logic [W-1:0] TOP = W'(MAX);

    always_comb begin
        carry_n_o  = ~((count_i == TOP) & ~up_lvl_i);
        borrow_n_o = ~((count_i == '0) & ~dn_lvl_i);
    end
endmodule

// File: rtl/updn_counter.sv
`timescale 1ns/1ps
module updn_counter
    import updn_ctr_pkg::*;
#(
    parameter int W           = 4,
    parameter bit DECADE      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_clk_i,
    input  logic         dn_clk_i,
    input  logic         load_n_i,
    input  logic         clear_i,
    input  logic [W-1:0] preset_i,
    output logic [W-1:0] count_o,
    output logic         carry_n_o,
    output logic         borrow_n_o
);
    localparam int MAX = DECADE ? 9 : (1 << W) - 1;

    typedef struct packed {
        logic [W-1:0] count;
    } ctr_state_t;

    ctr_state_t   state_d;
    ctr_state_t   state_q;
    logic         up_lvl;
    logic         up_rise;
    logic         dn_lvl;
    logic         dn_rise;
    step_e        step;
    logic [W-1:0] eff_count;
    logic [W-1:0] stepped;
    logic         forced;

    ctr_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (up_clk_i),
        .level_o (up_lvl),
        .rise_o  (up_rise)
    );

    ctr_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (dn_clk_i),
        .level_o (dn_lvl),
        .rise_o  (dn_rise)
    );

    ctr_step_decode u_step (
        .up_lvl_i  (up_lvl),
        .up_rise_i (up_rise),
        .dn_lvl_i  (dn_lvl),
        .dn_rise_i (dn_rise),
        .step_o    (step)
    );

    // Asynchronous overrides: clear first, then load, then the stored value
    always_comb begin
        forced = clear_i | ~load_n_i;
        if (clear_i) begin
            eff_count = '0;
        end else if (!load_n_i) begin
            eff_count = preset_i;
        end else begin
            eff_count = state_q.count;
        end
    end

    ctr_next_value #(.W(W), .DECADE(DECADE), .MAX(MAX)) u_next (
        .cur_i  (eff_count),
        .step_i (step),
        .nxt_o  (stepped)
    );

    always_comb begin
        state_d       = state_q;
        state_d.count = forced ? eff_count : stepped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = eff_count;

    ctr_terminal #(.W(W), .MAX(MAX)) u_term (
        .count_i    (eff_count),
        .up_lvl_i   (up_lvl),
        .dn_lvl_i   (dn_lvl),
        .carry_n_o  (carry_n_o),
        .borrow_n_o (borrow_n_o)
    );
endmodule

// File: rtl/updn_counter_chk.sv
`timescale 1ns/1ps
module updn_counter_chk #(
    parameter int W      = 4,
    parameter bit DECADE = 1'b1,
    parameter int MAX    = 9
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clear_i,
    input logic         load_n_i,
    input logic [W-1:0] preset_i,
    input logic [W-1:0] count_o,
    input logic         carry_n_o,
    input logic         borrow_n_o,
    input logic         up_lvl,
    input logic         up_rise,
    input logic         dn_lvl,
    input logic         dn_rise
);
    localparam logic [W-1:0] TOP = W'(MAX);

    logic quiet;
    assign quiet = !clear_i && load_n_i;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |-> count_o == '0); // R4

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n_i && !clear_i) |-> count_o == preset_i); // R5

    AST_CARRY_WHEN: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |-> (count_o == TOP && !up_lvl)); // R6

    AST_BORROW_WHEN: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n_o |-> (count_o == '0 && !dn_lvl)); // R7

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rise && dn_rise && quiet) |=> (!quiet || count_o == $past(count_o))); // R3

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rise && !dn_rise && dn_lvl && quiet && count_o < TOP)
        |=> (!quiet || count_o == W'($past(count_o) + 1'b1))); // R1

    AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_rise && !up_rise && up_lvl && quiet && count_o > '0 && count_o <= TOP)
        |=> (!quiet || count_o == W'($past(count_o) - 1'b1))); // R2

    generate
        if (DECADE) begin : g_dec_chk
            AST_STAY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
                (quiet && count_o <= TOP) |=> (!quiet || count_o <= TOP)); // R8
        end
    endgenerate
endmodule

bind updn_counter updn_counter_chk #(.W(W), .DECADE(DECADE), .MAX(MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .load_n_i   (load_n_i),
    .preset_i   (preset_i),
    .count_o    (count_o),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o),
    .up_lvl     (up_lvl),
    .up_rise    (up_rise),
    .dn_lvl     (dn_lvl),
    .dn_rise    (dn_rise)
);

// File: tb/tb_updn_counter.sv
`timescale 1ns/1ps
module tb_updn_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_clk = 1'b1;
    logic       dn_clk = 1'b1;
    logic       load_n = 1'b1;
    logic       clear = 1'b0;
    logic [3:0] preset = 4'd0;
    logic [3:0] cnt_dec;
    logic [3:0] cnt_bin;
    logic       carry_dec;
    logic       borrow_dec;
    logic       carry_bin;
    logic       borrow_bin;
    int         checks = 0;
    int         fails = 0;

    always #2.5 clk = ~clk;

    updn_counter #(.W(4), .DECADE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .up_clk_i(up_clk), .dn_clk_i(dn_clk),
        .load_n_i(load_n), .clear_i(clear), .preset_i(preset),
        .count_o(cnt_dec), .carry_n_o(carry_dec), .borrow_n_o(borrow_dec)
    );

    updn_counter #(.W(4), .DECADE(1'b0)) dut_bin (
        .clk(clk), .rst_n(rst_n), .up_clk_i(up_clk), .dn_clk_i(dn_clk),
        .load_n_i(load_n), .clear_i(clear), .preset_i(preset),
        .count_o(cnt_bin), .carry_n_o(carry_bin), .borrow_n_o(borrow_bin)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_low(input bit up);
        if (up) up_clk = 1'b0; else dn_clk = 1'b0;
        wait_n(4);
    endtask

    task automatic strobe_high(input bit up);
        if (up) up_clk = 1'b1; else dn_clk = 1'b1;
        wait_n(4);
    endtask

    task automatic do_load(input logic [3:0] v);
        preset = v;
        load_n = 1'b0;
        wait_n(2);
        load_n = 1'b1;
        wait_n(4);
    endtask

    function automatic int cnt_of(input bit bin);
        return bin ? int'(cnt_bin) : int'(cnt_dec);
    endfunction

    task automatic t_reset();
        chk("R10 count after reset", int'(cnt_dec), 0);
        chk("R10 carry after reset", int'(carry_dec), 1);
        chk("R10 borrow after reset", int'(borrow_dec), 1);
        chk("R10 binary count after reset", int'(cnt_bin), 0);
    endtask

    task automatic t_sequence(input bit bin, input logic [3:0] pre);
        int mx = bin ? 15 : 9;
        int exp = int'(pre);
        clear = 1'b1;
        wait_n(1);
        chk("R4 clear to zero", cnt_of(bin), 0);
        clear = 1'b0;
        wait_n(2);
        do_load(pre);
        chk("R5 preset value", cnt_of(bin), exp);
        for (int i = 0; i < 5; i++) begin
            strobe_low(1'b1);
            chk("R6 carry during up-low", int'(bin ? carry_bin : carry_dec), (exp == mx) ? 0 : 1);
            strobe_high(1'b1);
            exp = (exp == mx) ? 0 : exp + 1;
            chk("R1 R8 count up", cnt_of(bin), exp);
            chk("R6 carry after edge", int'(bin ? carry_bin : carry_dec), 1);
        end
        for (int i = 0; i < 5; i++) begin
            strobe_low(1'b0);
            chk("R7 borrow during down-low", int'(bin ? borrow_bin : borrow_dec), (exp == 0) ? 0 : 1);
            strobe_high(1'b0);
            exp = (exp == 0) ? mx : exp - 1;
            chk("R2 R8 count down", cnt_of(bin), exp);
            chk("R7 borrow after edge", int'(bin ? borrow_bin : borrow_dec), 1);
        end
    endtask

    task automatic t_gating();
        do_load(4'd5);
        strobe_low(1'b0);
        strobe_low(1'b1);
        strobe_high(1'b1);
        chk("R1 up edge ignored while down low", int'(cnt_dec), 5);
        strobe_high(1'b0);
        chk("R2 down edge with up high counts", int'(cnt_dec), 4);
    endtask

    task automatic t_simultaneous();
        do_load(4'd4);
        up_clk = 1'b0;
        dn_clk = 1'b0;
        wait_n(4);
        up_clk = 1'b1;
        dn_clk = 1'b1;
        wait_n(4);
        chk("R3 simultaneous edges hold", int'(cnt_dec), 4);
        chk("R3 binary simultaneous hold", int'(cnt_bin), 4);
    endtask

    task automatic t_overrides();
        do_load(4'd2);
        preset = 4'd3;
        load_n = 1'b0;
        #1;
        chk("R5 load visible before clock", int'(cnt_dec), 3);
        wait_n(1);
        strobe_low(1'b1);
        strobe_high(1'b1);
        chk("R5 strobe ignored during load", int'(cnt_dec), 3);
        preset = 4'd6;
        clear = 1'b1;
        #1;
        chk("R4 clear beats load", int'(cnt_dec), 0);
        wait_n(1);
        strobe_low(1'b1);
        strobe_high(1'b1);
        chk("R4 strobe ignored during clear", int'(cnt_dec), 0);
        clear = 1'b0;
        #1;
        chk("R5 load after clear release", int'(cnt_dec), 6);
        wait_n(1);
        load_n = 1'b1;
        wait_n(4);
        chk("R5 value kept after load release", int'(cnt_dec), 6);
    endtask

    task automatic t_illegal();
        for (int v = 10; v < 16; v++) begin
            int up_exp = (v % 2 == 1) ? 0 : v + 1;
            int dn_exp = (v == 10) ? 9 : ((v % 2 == 1) ? v - 1 : 9);
            do_load(4'(v));
            strobe_low(1'b1);
            strobe_high(1'b1);
            chk("R9 decade illegal up", int'(cnt_dec), up_exp);
            do_load(4'(v));
            strobe_low(1'b0);
            strobe_high(1'b0);
            chk("R9 decade illegal down", int'(cnt_dec), dn_exp);
        end
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(3);
        t_reset();
        t_sequence(1'b0, 4'd7);
        t_sequence(1'b1, 4'd13);
        t_gating();
        t_simultaneous();
        t_overrides();
        t_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule